// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block terminates posted message-signalled interrupt writes. A write lands on one of 128 index registers, arranged as 16 groups of 8. Each index register holds 16 vector bits, so the bank covers 2048 vectors. The write address picks the group and the index register. The write data value picks which bit to set.

Each group has a summary register that flags which of its index registers hold a pending bit. Each group also drives one level interrupt line. A handler reads the summary register for its group, then reads the index registers the summary points at. Reading an index register returns its contents and clears it. The handler can then read the summary again to catch anything that arrived in the meantime.

Top module: `msi_term_bank`

## Requirements
- R1: A write with `wr_addr` = (g << 19) + (x << 16), where g is 0..15 and x is 0..7, and `wr_data` = v (0..15) sets bit v of index register x of group g. It leaves every other bit unchanged, and repeated writes accumulate.
- R2: A read of an index register address returns its 16-bit value on `rd_data` in the cycle after `rd_en` and clears the register. `rd_data` is zero in any cycle that does not follow a read strobe.
- R3: A read at 0x800000 + (g << 16) returns the summary of group g. Bit x (0..7) is 1 exactly when index register x of group g is nonzero, and bits 15:8 are zero.
- R4: `irq_o[g]` is high exactly while some index register of group g holds a set bit.
- R5: After every index register of a group has been read with no writes in between, the group's summary reads zero and its interrupt line is low.
- R6: When a write and a clearing read hit the same index register in the same cycle, the read returns the value from before the write and the register keeps the newly written bit.
- R7: A write whose data value is 16 or larger changes no register.
- R8: A write is ignored if any of address bits 15:0 is set, if its address lies at or above 0x800000, or if it targets a summary register.
- R9: A read of any address that is neither an index register nor a summary register returns zero and clears nothing.
- R10: A synchronous active-high `rst` clears every pending bit, so all interrupt lines drop and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 24 | Write byte offset |
| wr_data | input | 32 | Write data, the vector number |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Read byte offset |
| rd_data | output | 16 | Read result, one cycle after the strobe |
| irq_o | output | 16 | Per-group level interrupt |

## Verification
The bench targets the collision in which a write and a clearing read hit the same register in the same cycle. A design that orders the clear after the set would lose the new vector. A design that forwards the write into the read would report the new vector twice.

The bench also sends stray writes: data values past 15, addresses with low offset bits set, and writes to the summary and unmapped space. A design that decodes too few address bits would alias these onto real registers and set pending bits. Draining a whole group and reading its summary exposes a summary or interrupt line that is left stuck high.

A long mixed sequence of writes and reads, compared against a model of the bank, catches bits that go to the wrong group or index.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int unsigned MSI_GROUPS = 16;
    localparam int unsigned MSI_IDX    = 8;
    localparam int unsigned MSI_VECS   = 16;
    localparam int unsigned MSI_ADDR_W = 24;
    localparam int unsigned MSI_DATA_W = 32;

    localparam int unsigned GRP_BITS  = $clog2(MSI_GROUPS);
    localparam int unsigned IDX_BITS  = $clog2(MSI_IDX);
    localparam int unsigned VEC_BITS  = $clog2(MSI_VECS);
    localparam int unsigned SLOT_BITS = 16;
    localparam int unsigned IDX_SHIFT = SLOT_BITS;
    localparam int unsigned GRP_SHIFT = SLOT_BITS + IDX_BITS;

    typedef struct packed {
        logic                is_idx;
        logic                is_sum;
        logic [GRP_BITS-1:0] grp;
        logic [IDX_BITS-1:0] idx;
    } msi_dec_t;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_pkg::*;
#(
    parameter int unsigned ADDR_W = MSI_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output msi_dec_t          dec
);

    localparam int unsigned TOP      = ADDR_W - 1;
    localparam int unsigned SUM_GAP  = TOP - (SLOT_BITS + GRP_BITS);

    logic low_clear;
    logic sum_gap_clear;

    always_comb begin
        low_clear     = (addr[SLOT_BITS-1:0] == '0);
        sum_gap_clear = (addr[TOP-1 -: SUM_GAP] == '0);
        dec.is_idx    = !addr[TOP] && low_clear;
        dec.is_sum    = addr[TOP] && sum_gap_clear && low_clear;
        dec.idx       = addr[IDX_SHIFT +: IDX_BITS];
        if (addr[TOP]) begin
            dec.grp = addr[SLOT_BITS +: GRP_BITS];
        end else begin
            dec.grp = addr[GRP_SHIFT +: GRP_BITS];
        end
    end

endmodule

// File: rtl/msi_group.sv
module msi_group
    import msi_pkg::*;
#(
    parameter int unsigned NIDX = MSI_IDX,
    parameter int unsigned NVEC = MSI_VECS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          set_en,
    input  logic [$clog2(NIDX)-1:0]       set_idx,
    input  logic [$clog2(NVEC)-1:0]       set_vec,
    input  logic                          clr_en,
    input  logic [$clog2(NIDX)-1:0]       clr_idx,
    output logic [NIDX-1:0][NVEC-1:0]     regs_o,
    output logic [NIDX-1:0]               summary_o,
    output logic                          irq_o
);

    localparam int unsigned IB = $clog2(NIDX);

    typedef struct packed {
        logic [NIDX-1:0][NVEC-1:0] regs;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NIDX; i++) begin
            if (clr_en && (clr_idx == IB'(i))) begin
                st_d.regs[i] = '0;
            end
            if (set_en && (set_idx == IB'(i))) begin
                st_d.regs[i][set_vec] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NIDX; i++) begin
            summary_o[i] = |st_q.regs[i];
        end
    end

    assign regs_o = st_q.regs;
    assign irq_o  = |summary_o;

    for (genvar i = 0; i < NIDX; i++) begin : g_chk
        // R1
        set_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (set_en && set_idx == IB'(i)) |=> (st_q.regs[i] != '0));
        // R2
        clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_idx == IB'(i) && !(set_en && set_idx == IB'(i)))
            |=> (st_q.regs[i] == '0));
        // R6
        collide_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_idx == IB'(i) && set_en && set_idx == IB'(i))
            |=> ($countones(st_q.regs[i]) == 1));
    end

endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
    import msi_pkg::*;
#(
    parameter int unsigned NGRP   = MSI_GROUPS,
    parameter int unsigned NIDX   = MSI_IDX,
    parameter int unsigned NVEC   = MSI_VECS,
    parameter int unsigned ADDR_W = MSI_ADDR_W,
    parameter int unsigned DATA_W = MSI_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NVEC-1:0]   rd_data,
    output logic [NGRP-1:0]   irq_o
);

    localparam int unsigned VB = $clog2(NVEC);
    localparam int unsigned GB = $clog2(NGRP);

    msi_dec_t wdec, rdec;
    logic     vec_ok;
    logic [NGRP-1:0] wr_hit;
    logic [NGRP-1:0] rd_hit;
    logic [NGRP-1:0][NIDX-1:0][NVEC-1:0] regs;
    logic [NGRP-1:0][NIDX-1:0]           summ;

    typedef struct packed {
        logic [NVEC-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    msi_addr_decode #(.ADDR_W(ADDR_W)) u_wdec (.addr(wr_addr), .dec(wdec));
    msi_addr_decode #(.ADDR_W(ADDR_W)) u_rdec (.addr(rd_addr), .dec(rdec));

    assign vec_ok = (wr_data[DATA_W-1:VB] == '0);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign wr_hit[g] = wr_en && wdec.is_idx && vec_ok && (wdec.grp == GB'(g));
        assign rd_hit[g] = rd_en && rdec.is_idx && (rdec.grp == GB'(g));

        msi_group #(.NIDX(NIDX), .NVEC(NVEC)) u_grp (
            .clk       (clk),
            .rst       (rst),
            .set_en    (wr_hit[g]),
            .set_idx   (wdec.idx),
            .set_vec   (wr_data[VB-1:0]),
            .clr_en    (rd_hit[g]),
            .clr_idx   (rdec.idx),
            .regs_o    (regs[g]),
            .summary_o (summ[g]),
            .irq_o     (irq_o[g])
        );

        // R4
        irq_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[g]) |-> $past(wr_hit[g]));
    end

    always_comb begin
        st_d.rdata = '0;
        if (rd_en) begin
            if (rdec.is_idx) begin
                st_d.rdata = regs[rdec.grp][rdec.idx];
            end else if (rdec.is_sum) begin
                st_d.rdata = NVEC'(summ[rdec.grp]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;

    // R2
    rdata_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data != '0) |-> $past(rd_en));

    // R7
    bad_vec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !vec_ok && !rd_en) |=> $stable(irq_o));

endmodule

// File: tb/tb_msi_term_bank.sv
module tb_msi_term_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] irq_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdl [16][8];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    msi_term_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [23:0] ia(int g, int x);
        return 24'((g << 19) | (x << 16));
    endfunction

    function automatic logic [23:0] sa(int g);
        return 24'(32'h800000 | (g << 16));
    endfunction

    function automatic logic [15:0] model_read(logic [23:0] a);
        logic [15:0] r = '0;
        if (a[15:0] == 0 && !a[23]) begin
            r = mdl[a[22:19]][a[18:16]];
        end else if (a[15:0] == 0 && a[23] && a[22:20] == 0) begin
            for (int x = 0; x < 8; x++) r[x] = (mdl[a[19:16]][x] != 0);
        end
        return r;
    endfunction

    function automatic logic [15:0] model_irq();
        logic [15:0] m = '0;
        for (int g = 0; g < 16; g++)
            for (int x = 0; x < 8; x++)
                if (mdl[g][x] != 0) m[g] = 1'b1;
        return m;
    endfunction

    task automatic cyc(input logic we, input logic [23:0] wa, input logic [31:0] wd,
                       input logic re, input logic [23:0] ra, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        if (re) begin
            exp_q.push_back(model_read(ra));
            tag_q.push_back(tag);
            if (ra[15:0] == 0 && !ra[23]) mdl[ra[22:19]][ra[18:16]] = '0;
        end
        if (we && wa[15:0] == 0 && !wa[23] && wd < 16)
            mdl[wa[22:19]][wa[18:16]][wd[3:0]] = 1'b1;
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, '0, tag);
    endtask

    task automatic rd(input logic [23:0] a, input string tag);
        cyc(1'b0, '0, '0, 1'b1, a, tag);
    endtask

    task automatic idle_check_irq(input string tag);
        cyc(1'b0, '0, '0, 1'b0, '0, tag);
        checks++;
        if (irq_o !== model_irq()) begin
            errors++;
            $display("FAIL %s irq: actual=%h expected=%h", tag, irq_o, model_irq());
        end
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s read: actual=%h expected=%h", t, rd_data, e);
            end
        end
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int g = 0; g < 16; g++) for (int x = 0; x < 8; x++) mdl[g][x] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        idle_check_irq("R10");
        rd(ia(0, 0), "R10");
        rd(sa(0), "R10");
        // R1 R3 R4 R2
        wr(ia(3, 5), 32'd9, "R1");
        idle_check_irq("R4");
        rd(sa(3), "R3");
        rd(ia(3, 5), "R1");
        rd(ia(3, 5), "R2");
        idle_check_irq("R2");
        // R1 accumulation at the top corner
        wr(ia(15, 7), 32'd0, "R1");
        wr(ia(15, 7), 32'd15, "R1");
        wr(ia(15, 7), 32'd15, "R1");
        rd(ia(15, 7), "R1");
        // R7 out-of-range data
        wr(ia(1, 0), 32'd16, "R7");
        wr(ia(1, 0), 32'h100, "R7");
        wr(ia(1, 0), 32'h80000003, "R7");
        idle_check_irq("R7");
        rd(ia(1, 0), "R7");
        // R8 stray addresses
        wr(ia(2, 1) | 24'h4, 32'd3, "R8");
        wr(ia(2, 1) | 24'h8000, 32'd3, "R8");
        wr(sa(2), 32'd3, "R8");
        wr(24'h900000, 32'd3, "R8");
        wr(24'hF00000, 32'd3, "R8");
        idle_check_irq("R8");
        rd(ia(2, 1), "R8");
        rd(sa(2), "R8");
        // R9 unmapped reads, and they clear nothing
        wr(ia(0, 0), 32'd4, "R9");
        rd(24'h000010, "R9");
        rd(24'h810004, "R9");
        rd(24'hA00000, "R9");
        rd(24'hFF0000, "R9");
        idle_check_irq("R9");
        rd(ia(0, 0), "R9");
        // R5 drain a whole group
        for (int x = 0; x < 8; x++) wr(ia(6, x), 32'(x * 2), "R5");
        wr(ia(6, 3), 32'd11, "R5");
        rd(sa(6), "R5");
        for (int x = 0; x < 8; x++) rd(ia(6, x), "R5");
        rd(sa(6), "R5");
        idle_check_irq("R5");
        // R6 collision
        wr(ia(4, 2), 32'd1, "R6");
        cyc(1'b1, ia(4, 2), 32'd7, 1'b1, ia(4, 2), "R6");
        idle_check_irq("R6");
        rd(ia(4, 2), "R6");
        // R6 collision on an empty register
        cyc(1'b1, ia(9, 0), 32'd2, 1'b1, ia(9, 0), "R6");
        rd(ia(9, 0), "R6");
        // R1 R2 R3 mixed traffic
        for (int n = 0; n < 400; n++) begin
            int g = $urandom_range(0, 15);
            int x = $urandom_range(0, 7);
            int k = $urandom_range(0, 3);
            if (k == 0) cyc(1'b1, ia(g, x), 32'($urandom_range(0, 15)), 1'b1,
                            ia($urandom_range(0, 15), $urandom_range(0, 7)), "R6");
            else if (k == 1) rd(ia(g, x), "R2");
            else if (k == 2) rd(sa(g), "R3");
            else wr(ia(g, x), 32'($urandom_range(0, 15)), "R1");
            if (n % 25 == 0) idle_check_irq("R4");
        end
        // R10 reset clears everything
        wr(ia(12, 4), 32'd5, "R10");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rst = 1'b1;
        for (int g = 0; g < 16; g++) for (int x = 0; x < 8; x++) mdl[g][x] = '0;
        exp_q.delete(); tag_q.delete();
        @(negedge clk);
        rst = 1'b0;
        idle_check_irq("R10");
        rd(ia(12, 4), "R10");
        rd(sa(12), "R10");
        idle_check_irq("R10");
        idle_check_irq("R10");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule